// File: doc/BRIEF.md
# Frequency Window Stability Checker

This block decides whether a free-running clock has settled near a wanted frequency. It runs on the monitored clock itself and counts that clock's cycles across a window of a fixed number of reference-clock periods. The reference clock is much slower, and the block treats it as a data input: it passes it through a two-flop synchronizer and detects its rising edges. At the end of every window the count is latched, compared against a programmable target with a programmable tolerance, and a new window starts at once.

A stable flag goes high only after two windows in a row fall inside the band. It drops at the end of any window that falls outside the band. It also drops one cycle after the enable input goes low or the inactivity input goes high. Either of those two conditions also throws away the window in progress, so that after recovery the next window starts on a fresh reference edge. The surrounding logic supplies the target count, which it derives from the expected frequency ratio, and it trims the oscillator itself.

Top module: `freq_window_checker`

## Requirements
- R1: `stable` rises only at the end of the second of two back-to-back in-band windows. After a single in-band window it is still low.
- R2: `measCount` holds the number of `clkMon` cycles between two window-boundary reference rising edges, which is `WIN_REFS` reference periods. It updates only at a window end and otherwise keeps its value. A new window begins on the same edge that closes the previous one.
- R3: A window is in band when |measCount − target| ≤ tolerance. Both limits are inclusive: a difference equal to the tolerance is in band, and one more is out of band, above or below the target.
- R4: An out-of-band window clears `stable` at that window end and zeroes the count of in-band windows. Two fresh in-band windows are then needed before `stable` rises again.
- R5: When `enable` is low, `stable` is low from the next cycle on and the running window is dropped. After `enable` returns high, measurement restarts at the next reference rising edge and needs two complete windows to set `stable`. `measCount` keeps its last value while disabled.
- R6: When `inactive` is high, the block behaves exactly as it does for a low `enable`: `stable` clears, the window aborts, and there is a clean restart.
- R7: The cycle count saturates at 2^CNT_W − 1 and never wraps. A window longer than that reports the maximum value.
- R8: After reset, `stable` is 0 and `measCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkMon | input | 1 | Monitored clock; all state runs on it |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Measurement enable |
| inactive | input | 1 | Clock-inactivity indication from elsewhere; aborts and clears |
| refClk | input | 1 | Slow reference clock, sampled as data |
| target | input | CNT_W | Expected count per window |
| tolerance | input | CNT_W | Allowed absolute deviation from target |
| stable | output | 1 | Frequency settled inside the band |
| measCount | output | CNT_W | Count from the latest completed window |

## Verification
The properties assume that `refClk` stays high and low for at least three `clkMon` cycles each, so that the synchronizer sees every edge and each boundary produces exactly one rise. They also assume that `target` and `tolerance` change only between clock edges. The stimulus toggles the reference on falling `clkMon` edges with half-periods of 8 cycles or more, and it drives every control input on falling edges. Expected counts are exact multiples of the reference period, and each check is sampled in a cycle chosen with a margin of at least one reference period on either side of the window boundaries.

// File: rtl/fws_pkg.sv
package fws_pkg;
  typedef struct packed {
    logic abort;
    logic winStart;
    logic winEnd;
    logic counting;
  } strobe_t;
endpackage

// File: rtl/fws_ctrl.sv
module fws_ctrl
  import fws_pkg::*;
#(
  parameter int WIN_REFS = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    inactive,
  input  logic    refClk,
  output strobe_t strb
);
  localparam int REF_W = $clog2(WIN_REFS + 1);
  localparam logic [REF_W-1:0] LAST_REF = REF_W'(WIN_REFS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN} state_t;

  state_t          state;
  logic [1:0]      refSync;
  logic            refPrev;
  logic            refRise;
  logic            halt;
  logic [REF_W-1:0] refCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSync <= '0;
      refPrev <= 1'b0;
    end else begin
      refSync <= {refSync[0], refClk};
      refPrev <= refSync[1];
    end
  end

  assign refRise = refSync[1] & ~refPrev;
  assign halt    = ~enable | inactive;

  always_comb begin
    strb.abort    = halt;
    strb.winStart = !halt && (state == ST_ARM) && refRise;
    strb.winEnd   = !halt && (state == ST_RUN) && refRise && (refCnt == LAST_REF);
    strb.counting = !halt && (state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      refCnt <= '0;
    end else if (halt) begin
      state  <= ST_IDLE;
      refCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: state <= ST_ARM;
        ST_ARM: if (refRise) begin
          state  <= ST_RUN;
          refCnt <= '0;
        end
        ST_RUN: if (refRise) begin
          refCnt <= (refCnt == LAST_REF) ? '0 : refCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.abort, strb.winStart, strb.winEnd})); // R5
  AST_RESTART_VIA_ARM: assert property (@(posedge clk) disable iff (!rstN)
    $past(halt) && !halt |-> !strb.winEnd); // R5
endmodule

// File: rtl/fws_data.sv
module fws_data
  import fws_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [CNT_W-1:0] target,
  input  logic [CNT_W-1:0] tolerance,
  output logic             stable,
  output logic [CNT_W-1:0] measCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [1:0] GOOD_NEED = 2'd2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntInc;
  logic [CNT_W-1:0] absDiff;
  logic             inBand;
  logic [1:0]       goodCnt;

  assign cntInc  = (cnt == CNT_MAX) ? CNT_MAX : cnt + 1'b1;
  assign absDiff = (cntInc >= target) ? (cntInc - target) : (target - cntInc);
  assign inBand  = (absDiff <= tolerance);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      measCount <= '0;
      goodCnt   <= '0;
      stable    <= 1'b0;
    end else if (strb.abort) begin
      cnt     <= '0;
      goodCnt <= '0;
      stable  <= 1'b0;
    end else if (strb.winStart) begin
      cnt <= '0;
    end else if (strb.winEnd) begin
      measCount <= cntInc;
      cnt       <= '0;
      if (inBand) begin
        goodCnt <= (goodCnt == GOOD_NEED) ? GOOD_NEED : goodCnt + 1'b1;
        stable  <= (goodCnt != 2'd0);
      end else begin
        goodCnt <= '0;
        stable  <= 1'b0;
      end
    end else if (strb.counting) begin
      cnt <= cntInc;
    end
  end

  AST_RISE_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stable) |-> $past(strb.winEnd)); // R1
  AST_RISE_NEEDS_PRIOR_GOOD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stable) |-> $past(goodCnt) != 2'd0); // R1
  AST_MEAS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.winEnd |=> $stable(measCount)); // R2
  AST_OUTBAND_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    strb.winEnd && !inBand |=> !stable && goodCnt == 2'd0); // R4
  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> !stable && goodCnt == 2'd0); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.counting && !strb.winEnd && cnt == CNT_MAX |=> cnt == CNT_MAX); // R7
endmodule

// File: rtl/freq_window_checker.sv
module freq_window_checker
  import fws_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int WIN_REFS = 4
) (
  input  logic             clkMon,
  input  logic             rstN,
  input  logic             enable,
  input  logic             inactive,
  input  logic             refClk,
  input  logic [CNT_W-1:0] target,
  input  logic [CNT_W-1:0] tolerance,
  output logic             stable,
  output logic [CNT_W-1:0] measCount
);
  strobe_t strb;

  fws_ctrl #(.WIN_REFS(WIN_REFS)) uCtrl (
    .clk      (clkMon),
    .rstN     (rstN),
    .enable   (enable),
    .inactive (inactive),
    .refClk   (refClk),
    .strb     (strb)
  );

  fws_data #(.CNT_W(CNT_W)) uData (
    .clk       (clkMon),
    .rstN      (rstN),
    .strb      (strb),
    .target    (target),
    .tolerance (tolerance),
    .stable    (stable),
    .measCount (measCount)
  );

  AST_DISABLE_CLEARS: assert property (@(posedge clkMon) disable iff (!rstN)
    !enable |=> !stable); // R5
  AST_INACTIVE_CLEARS: assert property (@(posedge clkMon) disable iff (!rstN)
    inactive |=> !stable); // R6
endmodule

// File: tb/sim_freq_window_checker.sv
`timescale 1ns/1ps
module sim_freq_window_checker;
  localparam int CW = 8;
  localparam int WR = 4;

  logic          clkMon = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic          inactive = 1'b0;
  logic          refClk = 1'b0;
  logic [CW-1:0] target = '0;
  logic [CW-1:0] tolerance = '0;
  logic          stable;
  logic [CW-1:0] measCount;

  int total = 0;
  int bad = 0;
  int halfP = 8;
  int cycles = 0;

  always #4 clkMon = ~clkMon;

  freq_window_checker #(.CNT_W(CW), .WIN_REFS(WR)) u0 (
    .clkMon(clkMon), .rstN(rstN), .enable(enable), .inactive(inactive),
    .refClk(refClk), .target(target), .tolerance(tolerance),
    .stable(stable), .measCount(measCount)
  );

  initial begin
    forever begin
      repeat (halfP) @(negedge clkMon);
      refClk = ~refClk;
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clkMon);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitFall(input int limit, output bit fell);
    fell = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clkMon);
      if (!stable) begin
        fell = 1'b1;
        break;
      end
    end
  endtask

  task automatic tReset();
    waitCycles(5);
    check("R8 stable after reset", int'(stable), 0);
    check("R8 measCount after reset", int'(measCount), 0);
    rstN = 1'b1;
    waitCycles(2);
  endtask

  task automatic tNominal();
    target = 8'd64; tolerance = 8'd3; halfP = 8;
    enable = 1'b1;
    waitCycles(100);
    check("R2 count of 4 periods of 16", int'(measCount), 64);
    check("R1 low after one window", int'(stable), 0);
    waitCycles(60);
    check("R1 high after two windows", int'(stable), 1);
  endtask

  task automatic tPeriod();
    halfP = 10;
    waitCycles(200);
    check("R2 count of 4 periods of 20", int'(measCount), 80);
    check("R4 out of band clears", int'(stable), 0);
    target = 8'd80;
    waitCycles(250);
    check("R3 exact match in band", int'(stable), 1);
    check("R2 count held value", int'(measCount), 80);
  endtask

  task automatic tFresh();
    bit fell;
    halfP = 8; target = 8'd64; tolerance = 8'd3;
    waitCycles(200);
    check("R1 settled again", int'(stable), 1);
    target = 8'd70;
    waitFall(200, fell);
    check("R4 drop on out of band", int'(fell), 1);
    check("R2 count at drop", int'(measCount), 64);
    target = 8'd64;
    waitCycles(96);
    check("R4 one fresh window not enough", int'(stable), 0);
    waitCycles(64);
    check("R4 two fresh windows set", int'(stable), 1);
  endtask

  task automatic tTolerance();
    bit fell;
    target = 8'd61;
    waitCycles(200);
    check("R3 diff equal tol below", int'(stable), 1);
    target = 8'd67;
    waitCycles(200);
    check("R3 diff equal tol above", int'(stable), 1);
    target = 8'd68;
    waitFall(150, fell);
    check("R3 diff tol+1 above", int'(fell), 1);
    target = 8'd60;
    waitCycles(200);
    check("R3 diff tol+1 below", int'(stable), 0);
    target = 8'd64;
    waitCycles(200);
    check("R3 back in band", int'(stable), 1);
  endtask

  task automatic tDisable();
    enable = 1'b0;
    waitCycles(2);
    check("R5 clears on disable", int'(stable), 0);
    waitCycles(100);
    check("R5 stays low disabled", int'(stable), 0);
    check("R5 count kept while disabled", int'(measCount), 64);
    enable = 1'b1;
    waitCycles(100);
    check("R5 restart one window", int'(stable), 0);
    waitCycles(60);
    check("R5 restart two windows", int'(stable), 1);
  endtask

  task automatic tInactive();
    inactive = 1'b1;
    waitCycles(2);
    check("R6 clears on inactive", int'(stable), 0);
    waitCycles(100);
    check("R6 stays low inactive", int'(stable), 0);
    inactive = 1'b0;
    waitCycles(100);
    check("R6 restart one window", int'(stable), 0);
    waitCycles(60);
    check("R6 restart two windows", int'(stable), 1);
  endtask

  task automatic tSaturate();
    halfP = 40; target = 8'd255; tolerance = 8'd0;
    waitCycles(1100);
    check("R7 saturated count", int'(measCount), 255);
    check("R7 saturated in band", int'(stable), 1);
  endtask

  initial begin
    forever begin
      @(posedge clkMon);
      cycles++;
      if (cycles > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    tReset();
    tNominal();
    tPeriod();
    tFresh();
    tTolerance();
    tDisable();
    tInactive();
    tSaturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule